// File: doc/BRIEF.md
# Advanced-Load Conflict Tracker

This block lets a compiler move loads above earlier stores that might write the same memory. When such a load runs early, it records its address in a small associative table, keyed by the register the load writes. Every store compares its address against all recorded entries in parallel. Any entry whose address lies in the same 8-byte granule is killed.

At the point where the load originally sat in program order, a check names the register. If that register's entry is still alive, execution continues and the entry is released. If the entry was killed, displaced or never made, the check asks for a branch to recovery code. The recovery code and the cache access are outside this block.

The table has a fixed number of entries. A load to a register that already has an entry overwrites that entry. A load that finds the table full evicts a victim picked in rotation. A later check on the evicted register fails, which is always safe.

Top module: `adv_load_guard`

## Requirements
- R1: While `rstN` is low, every entry is cleared and `chkDone`, `chkOk` and `chkFixup` are 0. After reset, a check on any register fails.
- R2: A check presented with `chkValid` high in cycle N gives `chkDone`=1 in cycle N+1, together with exactly one of `chkOk` or `chkFixup`. In a cycle after which no check was presented, `chkDone`, `chkOk` and `chkFixup` are 0.
- R3: A check on a register passes (`chkOk`=1) when an earlier load to that register was recorded and no conflicting store, displacement or release has happened since.
- R4: A check on a register that has no entry fails (`chkFixup`=1).
- R5: A store kills every entry whose address has the same granule as the store address. Two addresses share a granule when bits `[ADDR_W-1:3]` are equal. Entries in other granules are left untouched.
- R6: A load to a register that already has an entry overwrites that entry's address. A store to the old address then no longer affects the register.
- R7: A passing check releases its entry, so a second check on the same register fails.
- R8: When all entries are alive and a load brings a new register, the victim is chosen in rotation. The first victim after reset is entry 0, which is the first register loaded into an empty table. The evicted register's check then fails, and the other registers are unaffected.
- R9: A store and a check in the same cycle that hit the same entry make the check fail.
- R10: A load and a store in the same cycle to the same granule leave the load's new entry alive, because the load is taken as the younger operation.
- R11: No more than one entry ever holds a given register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ldValid | input | 1 | Record an advanced load this cycle |
| ldReg | input | REG_W | Destination register of the advanced load |
| ldAddr | input | ADDR_W | Byte address of the advanced load |
| stValid | input | 1 | A store is performed this cycle |
| stAddr | input | ADDR_W | Byte address of the store |
| chkValid | input | 1 | Check a register this cycle |
| chkReg | input | REG_W | Register to check |
| chkDone | output | 1 | A check result is present |
| chkOk | output | 1 | Checked load is still valid |
| chkFixup | output | 1 | Branch to recovery code requested |

## Verification
Loads, stores and releases change the table on the clock edge that samples them, so they affect a check issued in any later cycle. A check's verdict is registered and appears one cycle after `chkValid`. The bench drives every operation on a falling edge, lets one rising edge pass, and reads the outputs on the next falling edge. Each verdict is therefore compared in the cycle it is due, and the same-cycle interactions of R9 and R10 are driven together in a single step.

// File: rtl/alg_pkg.sv
package alg_pkg;
  localparam int NUM_ENTRIES = 8;
  localparam int IDX_W = $clog2(NUM_ENTRIES);

  // Strobes from the control to the datapath
  typedef struct packed {
    logic             insEn;
    logic [IDX_W-1:0] insIdx;
    logic             clrEn;
    logic [IDX_W-1:0] clrIdx;
    logic             killEn;
  } ctrl_strobes_t;
endpackage

// File: rtl/alg_datapath.sv
module alg_datapath
  import alg_pkg::*;
#(
  parameter int REG_W     = 7,
  parameter int ADDR_W    = 32,
  parameter int GRAN_BITS = 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrl_strobes_t          strobes,
  input  logic [REG_W-1:0]       ldReg,
  input  logic [ADDR_W-1:0]      ldAddr,
  input  logic [ADDR_W-1:0]      stAddr,
  input  logic [REG_W-1:0]       chkReg,
  output logic [NUM_ENTRIES-1:0] validVec,
  output logic [NUM_ENTRIES-1:0] ldRegHit,
  output logic [NUM_ENTRIES-1:0] chkRegHit,
  output logic [NUM_ENTRIES-1:0] stHit
);
  localparam int TAG_W = ADDR_W - GRAN_BITS;

  logic [NUM_ENTRIES-1:0] validQ;
  logic [REG_W-1:0]       regQ [NUM_ENTRIES];
  logic [TAG_W-1:0]       tagQ [NUM_ENTRIES];

  logic [TAG_W-1:0] ldTag, stTag;
  logic             unusedLowBits;

  assign ldTag = ldAddr[ADDR_W-1:GRAN_BITS];
  assign stTag = stAddr[ADDR_W-1:GRAN_BITS];
  assign unusedLowBits = ^{ldAddr[GRAN_BITS-1:0], stAddr[GRAN_BITS-1:0]};
  assign validVec = validQ;

  // Parallel compare of every entry
  always_comb begin
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      ldRegHit[i]  = validQ[i] && (regQ[i] == ldReg);
      chkRegHit[i] = validQ[i] && (regQ[i] == chkReg);
      stHit[i]     = validQ[i] && (tagQ[i] == stTag);
    end
  end

  // Insert wins over kill and release, so a load beside a store survives
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ <= '0;
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        regQ[i] <= '0;
        tagQ[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        if (strobes.insEn && (strobes.insIdx == IDX_W'(i))) begin
          validQ[i] <= 1'b1;
          regQ[i]   <= ldReg;
          tagQ[i]   <= ldTag;
        end else if ((strobes.killEn && stHit[i]) ||
                     (strobes.clrEn && (strobes.clrIdx == IDX_W'(i)))) begin
          validQ[i] <= 1'b0;
        end
      end
    end
  end

  // R11
  one_owner_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(chkRegHit) && $onehot0(ldRegHit));

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : gKillChk
    // R5
    store_kill_chk: assert property (@(posedge clk) disable iff (!rstN)
      (strobes.killEn && stHit[g] &&
       !(strobes.insEn && strobes.insIdx == IDX_W'(g))) |=> !validVec[g]);
  end
endmodule

// File: rtl/alg_control.sv
module alg_control
  import alg_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   ldValid,
  input  logic                   stValid,
  input  logic                   chkValid,
  input  logic [NUM_ENTRIES-1:0] validVec,
  input  logic [NUM_ENTRIES-1:0] ldRegHit,
  input  logic [NUM_ENTRIES-1:0] chkRegHit,
  input  logic [NUM_ENTRIES-1:0] stHit,
  output ctrl_strobes_t          strobes,
  output logic                   chkDone,
  output logic                   chkOk,
  output logic                   chkFixup
);
  logic [IDX_W-1:0] victimPtr;
  logic [IDX_W-1:0] sameRegIdx, freeIdx, chkIdx;
  logic             freeAny, useVictim, passNow;
  logic             chkDoneQ, chkOkQ;

  always_comb begin
    sameRegIdx = '0;
    chkIdx     = '0;
    freeIdx    = '0;
    freeAny    = 1'b0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (ldRegHit[i])  sameRegIdx = IDX_W'(i);
      if (chkRegHit[i]) chkIdx     = IDX_W'(i);
    end
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (!validVec[i]) begin
        freeIdx = IDX_W'(i);
        freeAny = 1'b1;
      end
    end
  end

  assign useVictim = ldValid && !(|ldRegHit) && !freeAny;
  // A same-cycle store that hits the checked entry makes it fail
  assign passNow = chkValid && |(chkRegHit & ~(stValid ? stHit : '0));

  always_comb begin
    strobes.insEn  = ldValid;
    strobes.insIdx = (|ldRegHit) ? sameRegIdx : (freeAny ? freeIdx : victimPtr);
    strobes.clrEn  = chkValid && (|chkRegHit);
    strobes.clrIdx = chkIdx;
    strobes.killEn = stValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      victimPtr <= '0;
      chkDoneQ  <= 1'b0;
      chkOkQ    <= 1'b0;
    end else begin
      chkDoneQ <= chkValid;
      chkOkQ   <= passNow;
      if (useVictim) begin
        if (victimPtr == IDX_W'(NUM_ENTRIES - 1)) victimPtr <= '0;
        else                                       victimPtr <= victimPtr + 1'b1;
      end
    end
  end

  assign chkDone  = chkDoneQ;
  assign chkOk    = chkDoneQ && chkOkQ;
  assign chkFixup = chkDoneQ && !chkOkQ;

  // R2
  verdict_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(chkOk && chkFixup));

  // R2
  verdict_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    chkValid |=> chkDone);

  // R2
  verdict_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !chkValid |=> !chkDone);

  // R9
  same_cycle_kill_chk: assert property (@(posedge clk) disable iff (!rstN)
    (chkValid && stValid && |(chkRegHit & stHit)) |=> chkFixup);
endmodule

// File: rtl/adv_load_guard.sv
module adv_load_guard
  import alg_pkg::*;
#(
  parameter int REG_W     = 7,
  parameter int ADDR_W    = 32,
  parameter int GRAN_BITS = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ldValid,
  input  logic [REG_W-1:0]  ldReg,
  input  logic [ADDR_W-1:0] ldAddr,
  input  logic              stValid,
  input  logic [ADDR_W-1:0] stAddr,
  input  logic              chkValid,
  input  logic [REG_W-1:0]  chkReg,
  output logic              chkDone,
  output logic              chkOk,
  output logic              chkFixup
);
  ctrl_strobes_t          strobes;
  logic [NUM_ENTRIES-1:0] validVec, ldRegHit, chkRegHit, stHit;

  alg_datapath #(
    .REG_W(REG_W), .ADDR_W(ADDR_W), .GRAN_BITS(GRAN_BITS)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .ldReg(ldReg), .ldAddr(ldAddr), .stAddr(stAddr), .chkReg(chkReg),
    .validVec(validVec), .ldRegHit(ldRegHit), .chkRegHit(chkRegHit), .stHit(stHit)
  );

  alg_control u_control (
    .clk(clk), .rstN(rstN),
    .ldValid(ldValid), .stValid(stValid), .chkValid(chkValid),
    .validVec(validVec), .ldRegHit(ldRegHit), .chkRegHit(chkRegHit), .stHit(stHit),
    .strobes(strobes),
    .chkDone(chkDone), .chkOk(chkOk), .chkFixup(chkFixup)
  );
endmodule

// File: tb/adv_load_guard_tb.sv
module adv_load_guard_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ldValid = 1'b0, stValid = 1'b0, chkValid = 1'b0;
  logic [6:0]  ldReg = '0, chkReg = '0;
  logic [31:0] ldAddr = '0, stAddr = '0;
  logic        chkDone, chkOk, chkFixup;
  int          nTests = 0, nFail = 0;

  always #2 clk = ~clk;

  adv_load_guard u_dut (
    .clk(clk), .rstN(rstN),
    .ldValid(ldValid), .ldReg(ldReg), .ldAddr(ldAddr),
    .stValid(stValid), .stAddr(stAddr),
    .chkValid(chkValid), .chkReg(chkReg),
    .chkDone(chkDone), .chkOk(chkOk), .chkFixup(chkFixup)
  );

  task automatic expectBits(string req, logic [2:0] act, logic [2:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: {done,ok,fixup} actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic resetDut();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  // Drive one cycle of operations, then stop at the falling edge after the update
  task automatic step(logic lv, logic [6:0] lr, logic [31:0] la,
                      logic sv, logic [31:0] sa, logic cv, logic [6:0] cr);
    ldValid = lv; ldReg = lr; ldAddr = la;
    stValid = sv; stAddr = sa;
    chkValid = cv; chkReg = cr;
    @(negedge clk);
    ldValid = 1'b0; stValid = 1'b0; chkValid = 1'b0;
  endtask

  task automatic doLoad(logic [6:0] r, logic [31:0] a);  step(1, r, a, 0, 0, 0, 0); endtask
  task automatic doStore(logic [31:0] a);                step(0, 0, 0, 1, a, 0, 0); endtask

  task automatic doCheck(logic [6:0] r, logic expOk, string req);
    step(0, 0, 0, 0, 0, 1, r);
    expectBits(req, {chkDone, chkOk, chkFixup}, {1'b1, expOk, !expOk});
  endtask

  task automatic testReset();
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    expectBits("R1 outputs in reset", {chkDone, chkOk, chkFixup}, 3'b000);
    @(negedge clk);
    rstN = 1'b1;
    doCheck(7'd5, 1'b0, "R1 empty after reset");
    doCheck(7'd0, 1'b0, "R4 missing entry");
    step(0, 0, 0, 0, 0, 0, 0);
    expectBits("R2 idle cycle", {chkDone, chkOk, chkFixup}, 3'b000);
  endtask

  task automatic testPassAndRelease();
    resetDut();
    doLoad(7'd3, 32'h100);
    doCheck(7'd3, 1'b1, "R3 pass with no store");
    doCheck(7'd3, 1'b0, "R7 second check after release");
  endtask

  task automatic testGranule();
    resetDut();
    doLoad(7'd4, 32'h200);
    doStore(32'h204);
    doCheck(7'd4, 1'b0, "R5 store in same granule kills");
    doLoad(7'd4, 32'h200);
    doStore(32'h208);
    doCheck(7'd4, 1'b1, "R5 store in next granule ignored");
    doLoad(7'd1, 32'h100);
    doLoad(7'd2, 32'h200);
    doStore(32'h107);
    doCheck(7'd2, 1'b1, "R5 other entry untouched");
    doCheck(7'd1, 1'b0, "R5 matching entry killed");
  endtask

  task automatic testReplace();
    resetDut();
    doLoad(7'd6, 32'h300);
    doLoad(7'd6, 32'h400);
    doStore(32'h300);
    doCheck(7'd6, 1'b1, "R6 old address no longer tracked");
    doLoad(7'd6, 32'h300);
    doLoad(7'd6, 32'h400);
    doStore(32'h400);
    doCheck(7'd6, 1'b0, "R6 new address tracked");
  endtask

  task automatic testSameCycle();
    resetDut();
    doLoad(7'd7, 32'h500);
    step(0, 0, 0, 1, 32'h500, 1, 7'd7);
    expectBits("R9 store beside check", {chkDone, chkOk, chkFixup}, 3'b101);
    step(1, 7'd8, 32'h600, 1, 32'h600, 0, 0);
    doCheck(7'd8, 1'b1, "R10 load beside store survives");
  endtask

  task automatic testFull();
    resetDut();
    for (int i = 0; i < 8; i++) doLoad(7'(10 + i), 32'h1000 + 32'(i) * 32'h10);
    doLoad(7'd20, 32'h2000);
    doCheck(7'd10, 1'b0, "R8 first victim evicted");
    doCheck(7'd11, 1'b1, "R8 neighbour kept");
    doCheck(7'd20, 1'b1, "R8 newcomer recorded");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nTests++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    testReset();
    testPassAndRelease();
    testGranule();
    testReplace();
    testSameCycle();
    testFull();
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule